// File: doc/BRIEF.md
# Switch Configuration Register Port over SPI

This block is a mode-0 SPI target that gives a host byte-wide access to the 8-bit-addressed control space of a small five-port switch. Each access is one chip-select-framed frame of exactly three bytes. The host sends an opcode byte, then a register address byte, then a data byte. On a write, the data byte lands in the addressed register. On a read, the target shifts the register value out on MISO while the third byte is clocked.

The space holds the following registers:
- a read-only family code at address 0x00;
- a combined chip-ID/start register at 0x01;
- four global control bytes at 0x02 to 0x05;
- one sixteen-byte bank per switch port, starting at 0x10 with a stride of 0x10.

Selected register bits are brought out as level outputs that steer the switch: the start bit, the 802.1Q VLAN enable, and per-port tag insert, tag remove, ingress filter and drop-non-PVID. SCLK, chip select and MOSI are synchronised into the system clock domain, and every register update happens in that domain. SCLK must therefore be several system clocks per half period.

Top module: `swcfg_spi_slave`

## Requirements
- R1: After reset every writable register holds zero, and sw_start, vlan_en, all per-port control outputs and spi_miso are low.
- R2: Address 0x00 always reads 0x95, and writes to it are ignored.
- R3: Address 0x01 reads as {4'h0 chip ID, 3'b000, start}. Bit 0 is writable and drives sw_start; the other bits read zero.
- R4: A frame whose first byte is 0x02 writes its third byte to the address in its second byte, once the 24th rising SCLK edge has been sampled. Global bytes 0x02 to 0x05 read back what was written.
- R5: A frame whose first byte is 0x03 returns the addressed register MSB first during the third byte. spi_miso stays low during the first two bytes.
- R6: Bit 7 of global register 0x05 drives vlan_en.
- R7: The bank for port p (0 to 4) is at 0x10 + 0x10*p. Bank offset 0x0 controls tagging: bit 2 drives port_tag_ins[p] and bit 1 drives port_tag_rm[p]. Bank offset 0x2 controls filtering: bit 6 drives port_ingress_filt[p] and bit 5 drives port_drop_nonpvid[p].
- R8: Bank offset 0xE of port p reads port_status[8p+7:8p], and writes to it are ignored.
- R9: Raising chip select before the 24th rising SCLK edge aborts the frame, and no register changes.
- R10: A frame with any opcode other than 0x02 or 0x03 writes nothing and keeps spi_miso low for the whole frame.
- R11: Unmapped addresses (0x06 to 0x0F and 0x60 to 0xFF) read zero, and writes to them are ignored.
- R12: Bits are sampled on rising SCLK, MSB first. SCLK edges beyond the 24th bit of a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-target serial data |
| spi_miso | output | 1 | Target-to-host serial data |
| port_status | input | 8*NUM_PORTS | Live status byte per port, read at bank offset 0xE |
| sw_start | output | 1 | Switch start/enable |
| vlan_en | output | 1 | 802.1Q VLAN enable |
| port_tag_ins | output | NUM_PORTS | Tag insert per port |
| port_tag_rm | output | NUM_PORTS | Tag remove per port |
| port_ingress_filt | output | NUM_PORTS | Ingress VLAN filtering per port |
| port_drop_nonpvid | output | NUM_PORTS | Drop frames whose VID differs from PVID |

## Verification
The in-line assertions check the following on every cycle:
- the bit counter never exceeds the frame length;
- a write strobe appears only on the cycle that samples the 24th bit, and only under an active chip select;
- spi_miso is low outside the data byte and while deselected;
- sw_start and vlan_en never move without a write strobe.

Only the bench scenarios can show the rest of the behaviour: the decoding of each address, the MSB-first content of read data, the read-only nature of the identification and status bytes, the mapping of bank bits to the per-port outputs, and the effects of aborted frames and unknown opcodes.

// File: rtl/swcfg_pkg.sv
package swcfg_pkg;
    localparam logic [7:0] OP_READ     = 8'h03;
    localparam logic [7:0] OP_WRITE    = 8'h02;
    localparam logic [7:0] FAMILY_CODE = 8'h95;
    localparam logic [3:0] CHIP_ID     = 4'h0;
    localparam int         FRAME_BITS  = 24;
    localparam int         CNT_W       = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [7:0]       sh;
        logic [7:0]       cmd;
        logic [7:0]       addr;
        logic [7:0]       tx;
        logic             miso;
        logic             wr;
        logic [7:0]       wr_addr;
        logic [7:0]       wr_data;
    } frame_st_t;
endpackage

// File: rtl/swcfg_spi_sync.sv
module swcfg_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic cs_act_o,
    output logic mosi_o
);
    typedef struct packed {
        logic [STAGES-1:0] sclk;
        logic [STAGES-1:0] csn;
        logic [STAGES-1:0] mosi;
        logic              sclk_prev;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.sclk      = {s_q.sclk[STAGES-2:0], sclk_i};
        s_d.csn       = {s_q.csn[STAGES-2:0], cs_n_i};
        s_d.mosi      = {s_q.mosi[STAGES-2:0], mosi_i};
        s_d.sclk_prev = s_q.sclk[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sclk      <= '0;
            s_q.csn       <= '1;
            s_q.mosi      <= '0;
            s_q.sclk_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk_rise_o = s_q.sclk[STAGES-1] & ~s_q.sclk_prev;
    assign sclk_fall_o = ~s_q.sclk[STAGES-1] & s_q.sclk_prev;
    assign cs_act_o    = ~s_q.csn[STAGES-1];
    assign mosi_o      = s_q.mosi[STAGES-1];
endmodule

// File: rtl/swcfg_spi_frame.sv
module swcfg_spi_frame
    import swcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_rise_i,
    input  logic       sclk_fall_i,
    input  logic       cs_act_i,
    input  logic       mosi_i,
    output logic [7:0] rd_addr_o,
    input  logic [7:0] rd_data_i,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       miso_o
);
    localparam logic [CNT_W-1:0] LAST_CMD_BIT  = CNT_W'(7);
    localparam logic [CNT_W-1:0] LAST_ADDR_BIT = CNT_W'(15);
    localparam logic [CNT_W-1:0] DATA_START    = CNT_W'(16);
    localparam logic [CNT_W-1:0] LAST_DATA_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FRAME_END     = CNT_W'(FRAME_BITS);

    frame_st_t f_d, f_q;
    logic [7:0] in_byte;

    assign in_byte   = {f_q.sh[6:0], mosi_i};
    assign rd_addr_o = in_byte;

    always_comb begin
        f_d    = f_q;
        f_d.wr = 1'b0;
        if (!cs_act_i) begin
            f_d.cnt  = '0;
            f_d.sh   = '0;
            f_d.cmd  = '0;
            f_d.tx   = '0;
            f_d.miso = 1'b0;
        end else begin
            if (sclk_rise_i && f_q.cnt != FRAME_END) begin
                f_d.sh  = in_byte;
                f_d.cnt = f_q.cnt + 1'b1;
                if (f_q.cnt == LAST_CMD_BIT) begin
                    f_d.cmd = in_byte;
                end
                if (f_q.cnt == LAST_ADDR_BIT) begin
                    f_d.addr = in_byte;
                    f_d.tx   = (f_q.cmd == OP_READ) ? rd_data_i : 8'h00;
                end
                if (f_q.cnt == LAST_DATA_BIT && f_q.cmd == OP_WRITE) begin
                    f_d.wr      = 1'b1;
                    f_d.wr_addr = f_q.addr;
                    f_d.wr_data = in_byte;
                end
            end
            if (sclk_fall_i && f_q.cnt > DATA_START) begin
                f_d.tx = {f_q.tx[6:0], 1'b0};
            end
            f_d.miso = (f_d.cnt >= DATA_START && f_d.cmd == OP_READ) ? f_d.tx[7] : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign wr_en_o   = f_q.wr;
    assign wr_addr_o = f_q.wr_addr;
    assign wr_data_o = f_q.wr_data;
    assign miso_o    = f_q.miso;

    a_r12_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= FRAME_END);

    a_r4_write_on_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.wr |-> (f_q.cnt == FRAME_END && $past(f_q.cnt) == LAST_DATA_BIT));

    a_r9_write_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.wr |-> $past(cs_act_i));

    a_r10_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act_i |=> !f_q.miso);

    a_r5_miso_quiet_header: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.cnt < DATA_START) |-> !f_q.miso);
endmodule

// File: rtl/swcfg_regfile.sv
module swcfg_regfile
    import swcfg_pkg::*;
#(
    parameter int         NUM_PORTS = 5,
    parameter logic [7:0] BANK_BASE = 8'h10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [7:0]             wr_addr_i,
    input  logic [7:0]             wr_data_i,
    input  logic [7:0]             rd_addr_i,
    output logic [7:0]             rd_data_o,
    input  logic [8*NUM_PORTS-1:0] port_status_i,
    output logic                   sw_start_o,
    output logic                   vlan_en_o,
    output logic [NUM_PORTS-1:0]   port_tag_ins_o,
    output logic [NUM_PORTS-1:0]   port_tag_rm_o,
    output logic [NUM_PORTS-1:0]   port_ingress_filt_o,
    output logic [NUM_PORTS-1:0]   port_drop_nonpvid_o
);
    localparam logic [7:0] ID_ADDR    = 8'h00;
    localparam logic [7:0] START_ADDR = 8'h01;
    localparam logic [7:0] GLOB_FIRST = 8'h02;
    localparam int         GLOB_NUM   = 4;
    localparam logic [7:0] GLOB_LAST  = GLOB_FIRST + 8'(GLOB_NUM - 1);
    localparam int         BANK_DEPTH = 16;
    localparam logic [3:0] BANK_FIRST = BANK_BASE[7:4];
    localparam logic [3:0] OFS_TAG    = 4'h0;
    localparam logic [3:0] OFS_FILT   = 4'h2;
    localparam logic [3:0] OFS_STATUS = 4'hE;
    localparam int         VLAN_REG   = 3;

    typedef struct packed {
        logic                                         start;
        logic [GLOB_NUM-1:0][7:0]                     glob;
        logic [NUM_PORTS-1:0][BANK_DEPTH-1:0][7:0]    bank;
    } rf_st_t;

    rf_st_t r_d, r_q;

    function automatic logic in_glob(input logic [7:0] a);
        return (a >= GLOB_FIRST) && (a <= GLOB_LAST);
    endfunction

    function automatic logic [1:0] glob_idx(input logic [7:0] a);
        logic [7:0] diff;
        diff = a - GLOB_FIRST;
        return diff[1:0];
    endfunction

    always_comb begin
        r_d = r_q;
        if (wr_en_i) begin
            if (wr_addr_i == START_ADDR) begin
                r_d.start = wr_data_i[0];
            end else if (in_glob(wr_addr_i)) begin
                r_d.glob[glob_idx(wr_addr_i)] = wr_data_i;
            end
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (wr_addr_i[7:4] == 4'(BANK_FIRST + 4'(p)) && wr_addr_i[3:0] != OFS_STATUS) begin
                    r_d.bank[p][wr_addr_i[3:0]] = wr_data_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data_o = 8'h00;
        if (rd_addr_i == ID_ADDR) begin
            rd_data_o = FAMILY_CODE;
        end else if (rd_addr_i == START_ADDR) begin
            rd_data_o = {CHIP_ID, 3'b000, r_q.start};
        end else if (in_glob(rd_addr_i)) begin
            rd_data_o = r_q.glob[glob_idx(rd_addr_i)];
        end
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_addr_i[7:4] == 4'(BANK_FIRST + 4'(p))) begin
                rd_data_o = (rd_addr_i[3:0] == OFS_STATUS) ? port_status_i[p*8 +: 8]
                                                           : r_q.bank[p][rd_addr_i[3:0]];
            end
        end
    end

    assign sw_start_o = r_q.start;
    assign vlan_en_o  = r_q.glob[VLAN_REG][7];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_out
        assign port_tag_ins_o[p]      = r_q.bank[p][OFS_TAG][2];
        assign port_tag_rm_o[p]       = r_q.bank[p][OFS_TAG][1];
        assign port_ingress_filt_o[p] = r_q.bank[p][OFS_FILT][6];
        assign port_drop_nonpvid_o[p] = r_q.bank[p][OFS_FILT][5];
    end

    a_r3_start_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(sw_start_o));

    a_r6_vlan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(vlan_en_o));
endmodule

// File: rtl/swcfg_spi_slave.sv
module swcfg_spi_slave
    import swcfg_pkg::*;
#(
    parameter int NUM_PORTS   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_sclk,
    input  logic                   spi_cs_n,
    input  logic                   spi_mosi,
    output logic                   spi_miso,
    input  logic [8*NUM_PORTS-1:0] port_status,
    output logic                   sw_start,
    output logic                   vlan_en,
    output logic [NUM_PORTS-1:0]   port_tag_ins,
    output logic [NUM_PORTS-1:0]   port_tag_rm,
    output logic [NUM_PORTS-1:0]   port_ingress_filt,
    output logic [NUM_PORTS-1:0]   port_drop_nonpvid
);
    logic       sclk_rise, sclk_fall, cs_act, mosi_s;
    logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
    logic       wr_en;

    swcfg_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (spi_sclk),
        .cs_n_i      (spi_cs_n),
        .mosi_i      (spi_mosi),
        .sclk_rise_o (sclk_rise),
        .sclk_fall_o (sclk_fall),
        .cs_act_o    (cs_act),
        .mosi_o      (mosi_s)
    );

    swcfg_spi_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise_i (sclk_rise),
        .sclk_fall_i (sclk_fall),
        .cs_act_i    (cs_act),
        .mosi_i      (mosi_s),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .miso_o      (spi_miso)
    );

    swcfg_regfile #(.NUM_PORTS(NUM_PORTS)) u_regs (
        .clk                 (clk),
        .rst_n               (rst_n),
        .wr_en_i             (wr_en),
        .wr_addr_i           (wr_addr),
        .wr_data_i           (wr_data),
        .rd_addr_i           (rd_addr),
        .rd_data_o           (rd_data),
        .port_status_i       (port_status),
        .sw_start_o          (sw_start),
        .vlan_en_o           (vlan_en),
        .port_tag_ins_o      (port_tag_ins),
        .port_tag_rm_o       (port_tag_rm),
        .port_ingress_filt_o (port_ingress_filt),
        .port_drop_nonpvid_o (port_drop_nonpvid)
    );
endmodule

// File: tb/swcfg_spi_slave_test.sv
`timescale 1ns/1ps
module swcfg_spi_slave_test;
    localparam int NP   = 5;
    localparam int HALF = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          spi_sclk = 1'b0;
    logic          spi_cs_n = 1'b1;
    logic          spi_mosi = 1'b0;
    logic          spi_miso;
    logic [8*NP-1:0] port_status;
    logic          sw_start, vlan_en;
    logic [NP-1:0] port_tag_ins, port_tag_rm, port_ingress_filt, port_drop_nonpvid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } item_t;

    item_t exp_q[$];
    item_t act_q[$];

    always #5 clk = ~clk;

    swcfg_spi_slave #(.NUM_PORTS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .port_status(port_status),
        .sw_start(sw_start), .vlan_en(vlan_en), .port_tag_ins(port_tag_ins),
        .port_tag_rm(port_tag_rm), .port_ingress_filt(port_ingress_filt),
        .port_drop_nonpvid(port_drop_nonpvid)
    );

    // Scoreboard monitor: compares actual items against expected ones
    always @(negedge clk) begin
        item_t e;
        item_t a;
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            e = exp_q.pop_front();
            a = act_q.pop_front();
            n_checks++;
            if (a.v !== e.v) begin
                n_fail++;
                $display("FAIL %s: actual 0x%02h expected 0x%02h", e.tag, a.v, e.v);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [23:0] w, input int nbits,
                        output logic [7:0] rd, output bit hdr_hi, output bit any_hi);
        rd = 8'h00; hdr_hi = 1'b0; any_hi = 1'b0;
        @(negedge clk); spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = w[23-i];
            repeat (HALF) @(negedge clk);
            if (spi_miso === 1'b1) begin
                any_hi = 1'b1;
                if (i < 16) hdr_hi = 1'b1;
            end
            if (i >= 16) rd = {rd[6:0], spi_miso};
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1; spi_mosi = 1'b0;
        repeat (2*HALF) @(negedge clk);
    endtask

    task automatic spi_write(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] rd; bit h; bit x;
        xfer({8'h02, a, d}, 24, rd, h, x);
    endtask

    task automatic spi_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] rd; bit h; bit x;
        exp_q.push_back('{v: exp, tag: tag});
        exp_q.push_back('{v: 8'h00, tag: {tag, " R5 header quiet"}});
        xfer({8'h03, a, 8'h00}, 24, rd, h, x);
        act_q.push_back('{v: rd, tag: tag});
        act_q.push_back('{v: {7'b0, h}, tag: tag});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd; bit h; bit x;
        for (int p = 0; p < NP; p++) port_status[p*8 +: 8] = 8'(8'h60 + p);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk("R1 sw_start", {7'b0, sw_start}, 8'h00);
        chk("R1 vlan_en", {7'b0, vlan_en}, 8'h00);
        chk("R1 miso", {7'b0, spi_miso}, 8'h00);
        chk("R1 tag_ins", {3'b0, port_tag_ins}, 8'h00);
        chk("R1 ingress", {3'b0, port_ingress_filt}, 8'h00);
        spi_read(8'h05, 8'h00, "R1 reg 0x05 reset");

        // R2 family code
        spi_read(8'h00, 8'h95, "R2 family code");
        spi_write(8'h00, 8'h12);
        spi_read(8'h00, 8'h95, "R2 family after write");

        // R3 start bit
        spi_read(8'h01, 8'h00, "R3 id/start reset");
        spi_write(8'h01, 8'hFF);
        chk("R3 sw_start set", {7'b0, sw_start}, 8'h01);
        spi_read(8'h01, 8'h01, "R3 id/start readback");

        // R4 global writes
        spi_write(8'h02, 8'hA5);
        spi_write(8'h03, 8'h3C);
        spi_write(8'h04, 8'h81);
        spi_read(8'h02, 8'hA5, "R4 glob 0x02");
        spi_read(8'h03, 8'h3C, "R4 glob 0x03");
        spi_read(8'h04, 8'h81, "R4 glob 0x04");

        // R6 VLAN enable
        spi_write(8'h05, 8'h80);
        chk("R6 vlan_en set", {7'b0, vlan_en}, 8'h01);
        spi_write(8'h05, 8'h7F);
        chk("R6 vlan_en clear", {7'b0, vlan_en}, 8'h00);
        spi_read(8'h05, 8'h7F, "R6 reg 0x05 readback");

        // R7 per-port banks
        for (int p = 0; p < NP; p++) begin
            spi_write(8'(8'h10 + 8'h10*p), (p % 2 == 0) ? 8'h04 : 8'h02);
            spi_write(8'(8'h12 + 8'h10*p), (p % 2 == 0) ? 8'h40 : 8'h20);
        end
        chk("R7 tag_ins", {3'b0, port_tag_ins}, 8'h15);
        chk("R7 tag_rm", {3'b0, port_tag_rm}, 8'h0A);
        chk("R7 ingress", {3'b0, port_ingress_filt}, 8'h15);
        chk("R7 drop_nonpvid", {3'b0, port_drop_nonpvid}, 8'h0A);
        spi_read(8'h30, 8'h04, "R7 port2 tag reg");
        spi_read(8'h42, 8'h20, "R7 port3 filt reg");
        spi_write(8'h1F, 8'h5A);
        spi_read(8'h1F, 8'h5A, "R7 port0 offset F");

        // R8 status read-only
        spi_read(8'h1E, 8'h60, "R8 port0 status");
        spi_read(8'h5E, 8'h64, "R8 port4 status");
        spi_write(8'h2E, 8'hFF);
        spi_read(8'h2E, 8'h61, "R8 status after write");

        // R9 aborted frames
        xfer({8'h02, 8'h03, 8'h00}, 20, rd, h, x);
        spi_read(8'h03, 8'h3C, "R9 abort after 20 bits");
        xfer({8'h02, 8'h01, 8'h00}, 8, rd, h, x);
        chk("R9 sw_start kept", {7'b0, sw_start}, 8'h01);

        // R10 unknown opcode
        xfer({8'h07, 8'h02, 8'h00}, 24, rd, h, x);
        chk("R10 miso quiet", {7'b0, x}, 8'h00);
        spi_read(8'h02, 8'hA5, "R10 no write");
        xfer({8'h83, 8'h00, 8'h00}, 24, rd, h, x);
        chk("R10 near-read opcode quiet", {7'b0, x}, 8'h00);

        // R11 unmapped addresses
        spi_write(8'h60, 8'hFF);
        spi_write(8'h08, 8'hFF);
        spi_read(8'h60, 8'h00, "R11 addr 0x60");
        spi_read(8'h08, 8'h00, "R11 addr 0x08");
        spi_read(8'hFF, 8'h00, "R11 addr 0xFF");

        // R12 extra bits ignored
        xfer({8'h02, 8'h04, 8'h3E}, 24, rd, h, x);
        spi_read(8'h04, 8'h3E, "R12 msb-first write");
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 32; i++) begin
            spi_mosi = (i < 24) ? logic'(24'h020477 >> (23 - i)) : 1'b1;
            repeat (HALF) @(negedge clk); spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk); spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1; spi_mosi = 1'b0;
        repeat (2*HALF) @(negedge clk);
        spi_read(8'h04, 8'h77, "R12 trailing bits ignored");

        spi_write(8'h01, 8'h00);
        chk("R3 sw_start clear", {7'b0, sw_start}, 8'h00);

        repeat (10) @(negedge clk);
        chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule